// File: doc/BRIEF.md
# Bus-Master DMA Register File

This block holds the software-visible control state for a two-channel bus-master disk DMA controller. Each channel has a command byte, a status byte, two spare bytes and a 32-bit pointer to a descriptor table in memory. Writes from the host are checked for size, and the side-effect rules of each register are applied as the write lands. The block then sends a one-cycle start or abort event to a separate DMA engine.

The engine reports the end of a transfer with a one-cycle completion event that names the channel. That event stops the channel and raises its interrupt. The block answers reads one cycle after the request, in little-endian order. Fetching descriptors and moving data are done elsewhere.

The access port carries a 4-bit byte offset. Bit 3 selects the channel (0 or 1) and bits 2:0 select the byte within the channel:

| Byte (bits 2:0) | Contents |
|---|---|
| 0 | command |
| 1 | spare A |
| 2 | status |
| 3 | spare B |
| 4 to 7 | descriptor pointer, least significant byte at 4 |

The size code is 0 for 8 bits, 1 for 16 bits, 2 for 32 bits and 3 for invalid.

Command bits:
- bit 0: run
- bit 3: transfer direction

Status bits:
- bit 0: active
- bit 1: error
- bit 2: interrupt
- bits 5 and 6: drive-DMA-capable flags, which are plain storage

Top module: `bm_dma_regs`

## Requirements
- R1: A write is accepted in only three forms: an 8-bit write to command, status or either spare byte; a 32-bit write at byte 4; nothing else. Byte writes take their data from bits 7:0. Any other write (wrong size, wrong alignment, or size code 3) changes no state and raises `acc_err` for exactly one cycle, in the cycle after the request.
- R2: After reset, the status byte of each channel reads 0x60 and every other byte reads 0. All event outputs and `irq` are 0.
- R3: A command write that changes run from 0 to 1 sets the channel's active bit. In the next cycle, `start_pulse` is high for one cycle, with `start_chan` and `start_ptr` equal to the channel's stored descriptor pointer.
- R4: A command write that changes run from 1 to 0 clears the active bit. In the next cycle, `abort_pulse` is high for one cycle, with `abort_chan` naming the channel.
- R5: While the active bit is set before a command write, the direction bit (bit 3) keeps its old value, whatever the written value.
- R6: A status write never changes the active bit.
- R7: The interrupt bit and the error bit each clear only when the written value has a 1 in that position while the bit is set. Writing a 0 keeps the bit. Software can never set either bit. Bits 5 and 6 store the written value.
- R8: A completion event for a channel clears that channel's run bit and active bit and sets its interrupt bit. `irq[c]` always equals channel c's interrupt bit.
- R9: If a completion event and a command write hit the same channel in the same cycle, the write is applied first and the completion is applied after it. No start or abort pulse is issued for that write.
- R10: A read returns `rd_valid` one cycle after the request. The data comes from the offset aligned down to the access size. The lowest-addressed byte is placed in bits 7:0, and lanes beyond the access size read 0. Size code 3 reads as 32 bits.
- R11: A command write that leaves the run bit unchanged issues no pulse and leaves the active bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_valid | input | 1 | Host access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_offset | input | 4 | Byte offset in the register window |
| acc_size | input | 2 | Access size code |
| acc_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| acc_err | output | 1 | Rejected write, one-cycle pulse |
| done_valid | input | 1 | Completion event from the DMA engine |
| done_chan | input | 1 | Channel of the completion event |
| start_pulse | output | 1 | Start event toward the engine |
| start_chan | output | 1 | Channel of the start event |
| start_ptr | output | 32 | Descriptor pointer for the start event |
| abort_pulse | output | 1 | Abort event toward the engine |
| abort_chan | output | 1 | Channel of the abort event |
| irq | output | 2 | Per-channel interrupt level |

## Verification
Every result of this block is due exactly one clock edge after the request or completion that causes it:
- read data and `rd_valid`;
- `acc_err`;
- start and abort pulses;
- the new register contents, including the level of `irq`.

The bench drives each stimulus half a cycle before an edge. Its behavioural model updates at that edge, and every output is compared at the following falling edge, so a result that arrives a cycle early or late shows up as a mismatch. Effects on register contents are seen through reads issued in later cycles, and the model expects those reads one edge after each read request.

// File: rtl/bm_regs_pkg.sv
// Shared constants and types for the bus-master DMA register file.
// Assumes two channels laid out back to back in a 16-byte window.
package bm_regs_pkg;
    localparam int NUM_CH    = 2;
    localparam int CH_BYTES  = 8;
    localparam int WIN_BYTES = NUM_CH * CH_BYTES;
    localparam int OFS_W     = $clog2(WIN_BYTES);
    localparam int CH_OFS_W  = $clog2(CH_BYTES);
    localparam int CH_W      = $clog2(NUM_CH);
    localparam int DATA_W    = 32;
    localparam int PTR_W     = 32;
    localparam int LANES     = DATA_W / 8;
    localparam int PTR_BYTES = PTR_W / 8;

    // byte positions inside one channel
    localparam int OFS_CMD     = 0;
    localparam int OFS_SPARE_A = 1;
    localparam int OFS_STS     = 2;
    localparam int OFS_SPARE_B = 3;
    localparam int OFS_PTR     = 4;

    // command bits
    localparam int CMD_RUN = 0;
    localparam int CMD_DIR = 3;
    // status bits
    localparam int STS_ACT = 0;
    localparam int STS_ERR = 1;
    localparam int STS_IRQ = 2;
    localparam logic [7:0] STS_RESET = 8'h60;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } acc_size_e;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_CMD,
        TGT_STS,
        TGT_PTR,
        TGT_SPARE_A,
        TGT_SPARE_B
    } tgt_e;

    typedef struct packed {
        tgt_e            tgt;
        logic [CH_W-1:0] chan;
        logic            bad;
    } wr_dec_t;
endpackage

// File: rtl/bm_wr_decode.sv
// Write decoder: maps offset and size of a host write onto a target
// register of one channel, or flags the write as malformed.
// Assumes one access per cycle; reads never reach this decoder's output.
module bm_wr_decode
    import bm_regs_pkg::*;
(
    input  logic             wr_req,
    input  logic [OFS_W-1:0] ofs,
    input  logic [1:0]       size,
    output wr_dec_t          dec
);
    logic [CH_OFS_W-1:0] lo;
    assign lo = ofs[CH_OFS_W-1:0];

    // classify the write by byte position and size
    always_comb begin
        dec.tgt  = TGT_NONE;
        dec.chan = ofs[OFS_W-1:CH_OFS_W];
        dec.bad  = 1'b0;
        if (wr_req) begin
            unique case (int'(lo))
                OFS_CMD: begin
                    if (size == SZ_BYTE) dec.tgt = TGT_CMD;
                    else                 dec.bad = 1'b1;
                end
                OFS_STS: begin
                    if (size == SZ_BYTE) dec.tgt = TGT_STS;
                    else                 dec.bad = 1'b1;
                end
                OFS_SPARE_A: begin
                    if (size == SZ_BYTE) dec.tgt = TGT_SPARE_A;
                    else                 dec.bad = 1'b1;
                end
                OFS_SPARE_B: begin
                    if (size == SZ_BYTE) dec.tgt = TGT_SPARE_B;
                    else                 dec.bad = 1'b1;
                end
                OFS_PTR: begin
                    if (size == SZ_WORD) dec.tgt = TGT_PTR;
                    else                 dec.bad = 1'b1;
                end
                default: dec.bad = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/bm_channel.sv
// One channel of bus-master registers with all write side effects:
// run-edge detection, direction lock, read-only active bit,
// write-one-to-clear interrupt/error, and completion handling.
// Assumes wr_tgt is already gated to TGT_NONE for other channels.
module bm_channel
    import bm_regs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  tgt_e             wr_tgt,
    input  logic [7:0]       wr_byte,
    input  logic [PTR_W-1:0] wr_word,
    input  logic             done,
    output logic [7:0]       cmd_q,
    output logic [7:0]       sts_q,
    output logic [7:0]       spare_a_q,
    output logic [7:0]       spare_b_q,
    output logic [PTR_W-1:0] ptr_q,
    output logic             start_ev,
    output logic             abort_ev
);
    logic [7:0]       cmd_d, sts_d, spare_a_d, spare_b_d;
    logic [PTR_W-1:0] ptr_d;

    // next-state of every register: software write first, completion last
    always_comb begin
        cmd_d     = cmd_q;
        sts_d     = sts_q;
        spare_a_d = spare_a_q;
        spare_b_d = spare_b_q;
        ptr_d     = ptr_q;
        start_ev  = 1'b0;
        abort_ev  = 1'b0;
        unique case (wr_tgt)
            TGT_CMD: begin
                cmd_d = wr_byte;
                if (sts_q[STS_ACT]) cmd_d[CMD_DIR] = cmd_q[CMD_DIR];
                if (!cmd_q[CMD_RUN] && wr_byte[CMD_RUN]) begin
                    sts_d[STS_ACT] = 1'b1;
                    start_ev       = !done;
                end else if (cmd_q[CMD_RUN] && !wr_byte[CMD_RUN]) begin
                    sts_d[STS_ACT] = 1'b0;
                    abort_ev       = !done;
                end
            end
            TGT_STS: begin
                sts_d          = wr_byte;
                sts_d[STS_ACT] = sts_q[STS_ACT];
                sts_d[STS_ERR] = sts_q[STS_ERR] & ~wr_byte[STS_ERR];
                sts_d[STS_IRQ] = sts_q[STS_IRQ] & ~wr_byte[STS_IRQ];
            end
            TGT_PTR:     ptr_d     = wr_word;
            TGT_SPARE_A: spare_a_d = wr_byte;
            TGT_SPARE_B: spare_b_d = wr_byte;
            default: ;
        endcase
        if (done) begin
            cmd_d[CMD_RUN] = 1'b0;
            sts_d[STS_ACT] = 1'b0;
            sts_d[STS_IRQ] = 1'b1;
        end
    end

    // register update with reset values
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q     <= '0;
            sts_q     <= STS_RESET;
            spare_a_q <= '0;
            spare_b_q <= '0;
            ptr_q     <= '0;
        end else begin
            cmd_q     <= cmd_d;
            sts_q     <= sts_d;
            spare_a_q <= spare_a_d;
            spare_b_q <= spare_b_d;
            ptr_q     <= ptr_d;
        end
    end
endmodule

// File: rtl/bm_read_port.sv
// Read path: aligns the offset to the access size, gathers the bytes
// little-endian from the flat register image and registers the result.
// Assumes one read per cycle at most; size code 3 reads as 32 bits.
module bm_read_port
    import bm_regs_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rd_req,
    input  logic [OFS_W-1:0]       ofs,
    input  logic [1:0]             size,
    input  logic [WIN_BYTES*8-1:0] image,
    output logic                   rd_valid,
    output logic [DATA_W-1:0]      rd_data
);
    logic [OFS_W-1:0]  base;
    logic [DATA_W-1:0] gather;

    // align the offset down to the access size
    always_comb begin
        unique case (size)
            SZ_BYTE: base = ofs;
            SZ_HALF: base = {ofs[OFS_W-1:1], 1'b0};
            default: base = {ofs[OFS_W-1:2], 2'b00};
        endcase
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [OFS_W-1:0] idx;
        logic             en;
        assign idx = base + OFS_W'(l);
        if (l == 0) begin : g_l0
            assign en = 1'b1;
        end else if (l == 1) begin : g_l1
            assign en = (size != SZ_BYTE);
        end else begin : g_hi
            assign en = (size == SZ_WORD) || (size == SZ_BAD);
        end
        assign gather[l*8 +: 8] = en ? image[{idx, 3'b000} +: 8] : 8'h00;
    end

    // one-cycle read response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_req;
            rd_data  <= rd_req ? gather : '0;
        end
    end
endmodule

// File: rtl/bm_dma_regs.sv
// Two-channel bus-master DMA register file. Decodes host writes, runs the
// per-channel side-effect logic, serves reads and registers the start,
// abort and error events toward the DMA engine and host.
// Assumes at most one host access and one completion per cycle.
module bm_dma_regs
    import bm_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [OFS_W-1:0]  acc_offset,
    input  logic [1:0]        acc_size,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              acc_err,
    input  logic              done_valid,
    input  logic [CH_W-1:0]   done_chan,
    output logic              start_pulse,
    output logic [CH_W-1:0]   start_chan,
    output logic [PTR_W-1:0]  start_ptr,
    output logic              abort_pulse,
    output logic [CH_W-1:0]   abort_chan,
    output logic [NUM_CH-1:0] irq
);
    wr_dec_t                dec;
    logic [7:0]             cmd_q     [NUM_CH];
    logic [7:0]             sts_q     [NUM_CH];
    logic [7:0]             spare_a_q [NUM_CH];
    logic [7:0]             spare_b_q [NUM_CH];
    logic [PTR_W-1:0]       ptr_q     [NUM_CH];
    logic [NUM_CH-1:0]      start_ev, abort_ev, act_vec;
    logic [WIN_BYTES*8-1:0] image;

    bm_wr_decode u_dec (
        .wr_req (acc_valid && acc_write),
        .ofs    (acc_offset),
        .size   (acc_size),
        .dec    (dec)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        tgt_e tgt_c;
        logic done_c;
        assign tgt_c  = (dec.chan == CH_W'(c)) ? dec.tgt : TGT_NONE;
        assign done_c = done_valid && (done_chan == CH_W'(c));

        bm_channel u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_tgt    (tgt_c),
            .wr_byte   (acc_wdata[7:0]),
            .wr_word   (acc_wdata[PTR_W-1:0]),
            .done      (done_c),
            .cmd_q     (cmd_q[c]),
            .sts_q     (sts_q[c]),
            .spare_a_q (spare_a_q[c]),
            .spare_b_q (spare_b_q[c]),
            .ptr_q     (ptr_q[c]),
            .start_ev  (start_ev[c]),
            .abort_ev  (abort_ev[c])
        );

        assign image[(c*CH_BYTES + OFS_CMD)*8 +: 8]     = cmd_q[c];
        assign image[(c*CH_BYTES + OFS_SPARE_A)*8 +: 8] = spare_a_q[c];
        assign image[(c*CH_BYTES + OFS_STS)*8 +: 8]     = sts_q[c];
        assign image[(c*CH_BYTES + OFS_SPARE_B)*8 +: 8] = spare_b_q[c];
        for (genvar p = 0; p < PTR_BYTES; p++) begin : g_pb
            assign image[(c*CH_BYTES + OFS_PTR + p)*8 +: 8] = ptr_q[c][p*8 +: 8];
        end
        assign act_vec[c] = sts_q[c][STS_ACT];
        assign irq[c]     = sts_q[c][STS_IRQ];
    end

    bm_read_port u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_req   (acc_valid && !acc_write),
        .ofs      (acc_offset),
        .size     (acc_size),
        .image    (image),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    logic              start_any, abort_any;
    logic [CH_W-1:0]   start_sel, abort_sel;
    logic [PTR_W-1:0]  start_sel_ptr;

    // pick the channel that raised a start or abort event
    always_comb begin
        start_any     = 1'b0;
        abort_any     = 1'b0;
        start_sel     = '0;
        abort_sel     = '0;
        start_sel_ptr = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (start_ev[c]) begin
                start_any     = 1'b1;
                start_sel     = CH_W'(c);
                start_sel_ptr = ptr_q[c];
            end
            if (abort_ev[c]) begin
                abort_any = 1'b1;
                abort_sel = CH_W'(c);
            end
        end
    end

    // register the outgoing event pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_pulse <= 1'b0;
            start_chan  <= '0;
            start_ptr   <= '0;
            abort_pulse <= 1'b0;
            abort_chan  <= '0;
            acc_err     <= 1'b0;
        end else begin
            start_pulse <= start_any;
            start_chan  <= start_sel;
            start_ptr   <= start_sel_ptr;
            abort_pulse <= abort_any;
            abort_chan  <= abort_sel;
            acc_err     <= dec.bad;
        end
    end
endmodule

// File: rtl/bm_dma_regs_chk.sv
// Property checker for bm_dma_regs, attached by bind below.
// Assumes the active-bit vector of the top is reachable by name.
module bm_dma_regs_chk
    import bm_regs_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [OFS_W-1:0]  acc_offset,
    input logic [1:0]        acc_size,
    input logic              rd_valid,
    input logic              acc_err,
    input logic              done_valid,
    input logic [CH_W-1:0]   done_chan,
    input logic              start_pulse,
    input logic [CH_W-1:0]   start_chan,
    input logic              abort_pulse,
    input logic [CH_W-1:0]   abort_chan,
    input logic [NUM_CH-1:0] irq,
    input logic [NUM_CH-1:0] act_vec
);
    logic cmd_wr_done_same;
    assign cmd_wr_done_same = acc_valid && acc_write && done_valid && (acc_size == SZ_BYTE)
                              && (acc_offset == {done_chan, CH_OFS_W'(OFS_CMD)});

    // R1
    one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_pulse, abort_pulse, acc_err}));

    // R3
    start_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> act_vec[start_chan]);

    // R4
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |-> !act_vec[abort_chan]);

    // R6
    sts_act_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && !done_valid && acc_offset[CH_OFS_W-1:0] == CH_OFS_W'(OFS_STS))
        |=> act_vec == $past(act_vec));

    // R8
    done_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> irq[$past(done_chan)] && !act_vec[$past(done_chan)]);

    // R9
    done_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr_done_same |=> !start_pulse && !abort_pulse);

    // R10
    rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write) |=> rd_valid);

    // R10
    rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && !acc_write) |=> !rd_valid);
endmodule

bind bm_dma_regs bm_dma_regs_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid   (acc_valid),
    .acc_write   (acc_write),
    .acc_offset  (acc_offset),
    .acc_size    (acc_size),
    .rd_valid    (rd_valid),
    .acc_err     (acc_err),
    .done_valid  (done_valid),
    .done_chan   (done_chan),
    .start_pulse (start_pulse),
    .start_chan  (start_chan),
    .abort_pulse (abort_pulse),
    .abort_chan  (abort_chan),
    .irq         (irq),
    .act_vec     (act_vec)
);

// File: tb/tb_bm_dma_regs.sv
// Bench for bm_dma_regs: a behavioural byte-array model stepped at each
// rising edge and compared with every output at the following falling edge.
module tb_bm_dma_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0, acc_write = 1'b0;
    logic [3:0]  acc_offset = '0;
    logic [1:0]  acc_size = '0;
    logic [31:0] acc_wdata = '0;
    logic        done_valid = 1'b0;
    logic        done_chan = 1'b0;
    logic        rd_valid, acc_err, start_pulse, start_chan, abort_pulse, abort_chan;
    logic [31:0] rd_data, start_ptr;
    logic [1:0]  irq;

    int n_chk = 0, n_bad = 0;
    string cur = "R2";
    logic [7:0] img [16];
    logic e_rdv, e_err, e_sp, e_sc, e_ap, e_ac;
    logic [31:0] e_rd, e_sptr;

    always #5 clk = ~clk;

    bm_dma_regs dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_offset(acc_offset), .acc_size(acc_size), .acc_wdata(acc_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .acc_err(acc_err),
        .done_valid(done_valid), .done_chan(done_chan),
        .start_pulse(start_pulse), .start_chan(start_chan), .start_ptr(start_ptr),
        .abort_pulse(abort_pulse), .abort_chan(abort_chan), .irq(irq)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic model_reset();
        for (int i = 0; i < 16; i++) img[i] = 8'h00;
        img[2] = 8'h60; img[10] = 8'h60;
        {e_rdv, e_err, e_sp, e_sc, e_ap, e_ac} = '0;
        e_rd = '0; e_sptr = '0;
    endtask

    // requirement-level model of one clock edge
    task automatic model_step(input logic v, w, input logic [3:0] ofs,
                              input logic [1:0] sz, input logic [31:0] wd,
                              input logic dv, dch);
        int b, lo, base, nl;
        logic ok, kill;
        logic [7:0] old, nv;
        {e_rdv, e_err, e_sp, e_ap} = '0;
        e_rd = '0;
        if (v && !w) begin
            e_rdv = 1;
            if (sz == 0)      begin base = ofs;        nl = 1; end
            else if (sz == 1) begin base = ofs & ~1;   nl = 2; end
            else              begin base = ofs & ~3;   nl = 4; end
            for (int l = 0; l < nl; l++) e_rd[l*8 +: 8] = img[(base + l) % 16];
        end
        if (v && w) begin
            b  = ofs[3] * 8;
            lo = ofs[2:0];
            ok = ((lo <= 3) && sz == 0) || (lo == 4 && sz == 2);
            kill = dv && (dch == ofs[3]);
            if (!ok) e_err = 1;
            else if (lo == 0) begin
                old = img[b];
                nv  = wd[7:0];
                if (img[b+2][0]) nv[3] = old[3];
                if (!old[0] && nv[0]) begin
                    img[b+2][0] = 1;
                    if (!kill) begin
                        e_sp = 1; e_sc = ofs[3];
                        e_sptr = {img[b+7], img[b+6], img[b+5], img[b+4]};
                    end
                end else if (old[0] && !nv[0]) begin
                    img[b+2][0] = 0;
                    if (!kill) begin e_ap = 1; e_ac = ofs[3]; end
                end
                img[b] = nv;
            end else if (lo == 2) begin
                old = img[b+2];
                nv  = wd[7:0];
                nv[0] = old[0];
                nv[1] = old[1] && !wd[1];
                nv[2] = old[2] && !wd[2];
                img[b+2] = nv;
            end else if (lo == 4) begin
                for (int p = 0; p < 4; p++) img[b+4+p] = wd[p*8 +: 8];
            end else begin
                img[b+lo] = wd[7:0];
            end
        end
        if (dv) begin
            b = dch * 8;
            img[b][0]   = 0;
            img[b+2][0] = 0;
            img[b+2][2] = 1;
        end
    endtask

    task automatic compare_all();
        chk(cur, "rd_valid", 32'(rd_valid), 32'(e_rdv));
        if (e_rdv) chk(cur, "rd_data", rd_data, e_rd);
        chk("R1", "acc_err", 32'(acc_err), 32'(e_err));
        chk("R3", "start_pulse", 32'(start_pulse), 32'(e_sp));
        if (e_sp) begin
            chk("R3", "start_chan", 32'(start_chan), 32'(e_sc));
            chk("R3", "start_ptr", start_ptr, e_sptr);
        end
        chk("R4", "abort_pulse", 32'(abort_pulse), 32'(e_ap));
        if (e_ap) chk("R4", "abort_chan", 32'(abort_chan), 32'(e_ac));
        chk("R8", "irq", 32'(irq), 32'({img[10][2], img[2][2]}));
    endtask

    // drive one cycle (called at a falling edge), step model, compare
    task automatic cyc(input logic v, w, input logic [3:0] ofs, input logic [1:0] sz,
                       input logic [31:0] wd, input logic dv, dch);
        acc_valid = v; acc_write = w; acc_offset = ofs; acc_size = sz;
        acc_wdata = wd; done_valid = dv; done_chan = dch;
        @(posedge clk);
        model_step(v, w, ofs, sz, wd, dv, dch);
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr(input logic [3:0] ofs, input logic [1:0] sz, input logic [31:0] wd);
        cyc(1, 1, ofs, sz, wd, 0, 0);
    endtask
    task automatic rd(input logic [3:0] ofs, input logic [1:0] sz);
        cyc(1, 0, ofs, sz, 0, 0, 0);
    endtask
    task automatic idle(input logic dv, dch);
        cyc(0, 0, 0, 0, 0, dv, dch);
    endtask

    initial begin
        #(200000 * 10);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cur = "R2";
        compare_all();
        rd(0, 2); rd(4, 2); rd(8, 2); rd(12, 2); rd(2, 0); rd(10, 0);

        cur = "R10";
        wr(4, 2, 32'h1234_5678);
        rd(4, 1); rd(6, 1); rd(5, 0); rd(7, 0); rd(4, 2); rd(5, 1); rd(6, 3); rd(3, 1);

        cur = "R1";
        wr(4, 0, 32'hFF); wr(0, 1, 32'h1); wr(2, 2, 32'h4); wr(0, 3, 32'h1);
        wr(1, 1, 32'hAB); wr(5, 2, 32'h0);
        wr(1, 0, 32'hC3); wr(11, 0, 32'h3C);
        rd(0, 2); rd(4, 2); rd(8, 2);

        cur = "R3";
        wr(0, 0, 32'h09); rd(2, 0); rd(0, 0);
        cur = "R11";
        wr(0, 0, 32'h09); rd(2, 0);
        cur = "R5";
        wr(0, 0, 32'h01); rd(0, 0);
        cur = "R6";
        wr(2, 0, 32'h00); rd(2, 0); wr(2, 0, 32'h61); rd(2, 0);
        cur = "R4";
        wr(0, 0, 32'h00); rd(0, 0); rd(2, 0); wr(0, 0, 32'h00); rd(0, 0);
        cur = "R11";
        wr(0, 0, 32'h00); rd(2, 0);

        cur = "R8";
        wr(12, 2, 32'hA5A5_0010); wr(8, 0, 32'h01); idle(0, 0);
        idle(1, 1); rd(8, 0); rd(10, 0);
        cur = "R7";
        wr(10, 0, 32'h00); rd(10, 0); wr(10, 0, 32'h02); rd(10, 0);
        wr(10, 0, 32'h04); rd(10, 0); wr(10, 0, 32'h06); rd(10, 0);
        wr(10, 0, 32'h00); rd(10, 0);

        cur = "R9";
        wr(0, 0, 32'h01);
        cyc(1, 1, 0, 0, 32'h00, 1, 0); rd(0, 0); rd(2, 0);
        cyc(1, 1, 0, 0, 32'h01, 1, 0); rd(0, 0); rd(2, 0);
        cyc(1, 1, 0, 0, 32'h01, 1, 1); rd(2, 0); rd(10, 0);
        cyc(1, 1, 2, 0, 32'h04, 1, 0); rd(2, 0);

        cur = "R10";
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom;
            cyc(r[0] | r[1], r[2], r[7:4], r[9:8],
                (r[10] ? 32'($urandom) : {24'h0, r[31:24]}), (r[13:11] == 3'd0), r[14]);
        end
        acc_valid = 0; done_valid = 0;
        summary();
    end
endmodule